// File: doc/BRIEF.md
# Round-Key Expansion Engine

This block turns a 128-bit master key into a set of 32 round keys of 32 bits each and holds them for a neighbouring cipher datapath. Software loads the key as four 32-bit words through a small register-style write/read port, then sets a start bit. The engine runs one nonlinear round per clock and writes each new round key into an internal flop array. Completion is reported through a status word.

The stored set is served through a separate combinational read port. That port takes a round index and a direction flag. In forward (encrypt) order, index n returns round key n. In reverse (decrypt) order, index n returns round key 31−n. Decryption therefore reuses the same stored keys, and the schedule never has to run a second time for a key that is already expanded.

The expansion state starts as the key words XORed with four fixed constants. Each round mixes three state words with a round constant. It passes the result bytewise through a computed substitution and a rotate-XOR diffusion, then folds that into the oldest state word.

Top module: `key_sched_engine`

## Requirements
- R1: After reset the status word reads 0, all four key words read 0, and every round key reads 0 through the read port in both directions.
- R2: Bus addresses 0 to 3 hold the key words and read back what was last written. Address 0 is master-key bits 127:96 and address 3 is bits 31:0.
- R3: Address 4 is control and status. A write with bit 0 set requests a start, and a write with bit 0 clear does nothing. A read returns busy in bit 0, done in bit 1 and zeros elsewhere. Addresses 5 to 7 read 0, and writes to them change nothing.
- R4: On an accepted start, state words X0..X3 are loaded with key words 0..3 XORed with A3B1BAC6, 56AA3350, 677D9197 and B27022DC, in that order.
- R5: Round i (0..31) computes rk[i] = X0 ^ L(T(X1^X2^X3^C(i))) and then shifts the state to {X1,X2,X3,rk[i]}. Here L(w) = w ^ rotl(w,13) ^ rotl(w,23). Byte j of C(i) is (4i+j)·7 mod 256, and byte 0 is bits 31:24.
- R6: T replaces each byte b with S(b) = Aff(Inv(b)). Inv is the inverse in GF(2^8) modulo x^8+x^4+x^3+x+1, with Inv(0)=0. Bit k of Aff(y) is the parity of y AND rotl8(0xE5,k), XORed with bit k of 0xD3.
- R7: Busy is high from the clock edge that accepts a start for exactly 32 cycles, with one round key written per cycle. Busy falls and done rises on the edge that writes rk[31], so all 32 keys are readable once done is seen.
- R8: Done stays set until the next accepted start, which clears it. A start issued while done is set starts a new expansion.
- R9: A start request while busy is ignored: the running expansion keeps its timing and its result.
- R10: Key-word writes during an expansion do not affect the keys being produced. The new words take effect at the next accepted start.
- R11: The read port returns rk[idx] when the direction flag is 0 and rk[31−idx] when it is 1, from the same stored set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_we_i | input | 1 | Register write strobe, one write per cycle |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data (combinational on address) |
| rd_idx_i | input | 5 | Round-key index |
| rd_dec_i | input | 1 | Direction: 0 forward, 1 reverse |
| rd_key_o | output | 32 | Selected round key |

## Verification
The hardest case to reach from the ports is a second start request that arrives in the middle of a run, right after the key words have been overwritten. A correct engine must finish the run on the original schedule and with the old key, yet later honour the new words. The stimulus starts a run from the done state. A few cycles in, it rewrites all four key words and issues another start. It then measures the busy window against the first start and compares all 64 reads with the schedule of the earlier key. A third start then confirms that the rewritten key was latched.

// File: rtl/ks_pkg.sv
package ks_pkg;

  localparam int WORD_W = 32;
  localparam int NWORDS = 4;
  localparam logic [7:0] GF_RED  = 8'h1B;
  localparam logic [7:0] AFF_ROW = 8'hE5;
  localparam logic [7:0] AFF_C   = 8'hD3;

  typedef enum logic [1:0] {CS_IDLE, CS_RUN, CS_DONE} ks_state_e;

  function automatic logic [WORD_W-1:0] fk_word(input int j);
    case (j)
      0:       return 32'hA3B1BAC6;
      1:       return 32'h56AA3350;
      2:       return 32'h677D9197;
      default: return 32'hB27022DC;
    endcase
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r;
    logic [7:0] aa;
    r  = 8'h00;
    aa = a;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) r = r ^ aa;
      aa = {aa[6:0], 1'b0} ^ (aa[7] ? GF_RED : 8'h00);
    end
    return r;
  endfunction

  // x^254 == x^-1 in GF(2^8); 0 maps to 0
  function automatic logic [7:0] gf_inv(input logic [7:0] x);
    logic [7:0] p;
    logic [7:0] r;
    p = x;
    r = 8'h01;
    for (int k = 0; k < 7; k++) begin
      p = gf_mul(p, p);
      r = gf_mul(r, p);
    end
    return r;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] x, input int n);
    logic [15:0] d;
    d = {x, x} << n;
    return d[15:8];
  endfunction

  function automatic logic [7:0] affine8(input logic [7:0] y);
    logic [7:0] o;
    for (int k = 0; k < 8; k++) o[k] = (^(y & rotl8(AFF_ROW, k))) ^ AFF_C[k];
    return o;
  endfunction

  function automatic logic [WORD_W-1:0] lin_mix(input logic [WORD_W-1:0] w);
    return w ^ {w[18:0], w[31:19]} ^ {w[8:0], w[31:9]};
  endfunction

  function automatic logic [WORD_W-1:0] round_const(input int i);
    logic [WORD_W-1:0] c;
    for (int j = 0; j < 4; j++) c[WORD_W-1-8*j -: 8] = 8'(((4 * i + j) * 7) & 255);
    return c;
  endfunction

endpackage

// File: rtl/ks_sbox_byte.sv
module ks_sbox_byte
  import ks_pkg::*;
(
  input  logic [7:0] a_i,
  output logic [7:0] s_o
);

  logic [7:0] inv;

  assign inv = gf_inv(a_i);
  assign s_o = affine8(inv);

endmodule

// File: rtl/ks_round.sv
module ks_round
  import ks_pkg::*;
#(
  parameter int RND_W = 5
) (
  input  logic [NWORDS-1:0][WORD_W-1:0] st_i,
  input  logic [RND_W-1:0]              rnd_i,
  output logic [WORD_W-1:0]             nxt_o
);

  localparam int NBYTES = WORD_W / 8;

  logic [WORD_W-1:0] mix;
  logic [WORD_W-1:0] sub;

  assign mix = st_i[1] ^ st_i[2] ^ st_i[3] ^ round_const(int'(rnd_i));

  for (genvar b = 0; b < NBYTES; b++) begin : g_sbox
    ks_sbox_byte u_sbox (
      .a_i(mix[8*b +: 8]),
      .s_o(sub[8*b +: 8])
    );
  end

  assign nxt_o = st_i[0] ^ lin_mix(sub);

endmodule

// File: rtl/ks_ctrl.sv
module ks_ctrl
  import ks_pkg::*;
#(
  parameter int ROUNDS = 32,
  parameter int RND_W  = $clog2(ROUNDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             load_o,
  output logic             step_o,
  output logic [RND_W-1:0] rnd_o
);

  localparam logic [RND_W-1:0] LAST = RND_W'(ROUNDS - 1);

  ks_state_e        st_q;
  logic [RND_W-1:0] rnd_q;
  logic             last;

  assign busy_o = (st_q == CS_RUN);
  assign done_o = (st_q == CS_DONE);
  assign load_o = start_i && !busy_o;
  assign step_o = busy_o;
  assign rnd_o  = rnd_q;
  assign last   = (rnd_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= CS_IDLE;
      rnd_q <= '0;
    end else if (load_o) begin
      st_q  <= CS_RUN;
      rnd_q <= '0;
    end else if (busy_o) begin
      if (last) begin
        st_q  <= CS_DONE;
        rnd_q <= '0;
      end else begin
        rnd_q <= rnd_q + 1'b1;
      end
    end
  end

  assert_accept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && rnd_q == '0));

  assert_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !last) |=> (busy_o && rnd_q == RND_W'($past(rnd_q) + 1'b1)));

  assert_last_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && last) |=> (done_o && !busy_o));

  assert_done_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);

  assert_busy_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !last) |=> (busy_o && rnd_q != '0));

endmodule

// File: rtl/ks_rk_file.sv
module ks_rk_file #(
  parameter int N  = 32,
  parameter int W  = 32,
  parameter int AW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  input  logic          rdec_i,
  output logic [W-1:0]  rdata_o
);

  localparam logic [AW-1:0] LAST_IDX = AW'(N - 1);

  logic [N-1:0][W-1:0] mem_q;
  logic [AW-1:0]       ridx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mem_q <= '0;
    else if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // reverse order is a mirrored index into the same storage
  assign ridx    = rdec_i ? (LAST_IDX - raddr_i) : raddr_i;
  assign rdata_o = mem_q[ridx];

  assert_rk_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (mem_q[$past(waddr_i)] == $past(wdata_i)));

  assert_rk_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mem_q));

endmodule

// File: rtl/key_sched_engine.sv
module key_sched_engine
  import ks_pkg::*;
#(
  parameter int ROUNDS = 32,
  parameter int RND_W  = $clog2(ROUNDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_we_i,
  input  logic [2:0]       bus_addr_i,
  input  logic [31:0]      bus_wdata_i,
  output logic [31:0]      bus_rdata_o,
  input  logic [RND_W-1:0] rd_idx_i,
  input  logic             rd_dec_i,
  output logic [31:0]      rd_key_o
);

  localparam logic [2:0] A_CTRL = 3'd4;

  logic [NWORDS-1:0][WORD_W-1:0] key_q;
  logic [NWORDS-1:0][WORD_W-1:0] st_q;
  logic                          key_wr;
  logic                          start_req;
  logic                          busy;
  logic                          done;
  logic                          load;
  logic                          step;
  logic [RND_W-1:0]              rnd;
  logic [WORD_W-1:0]             nxt;

  assign key_wr    = bus_we_i && !bus_addr_i[2];
  assign start_req = bus_we_i && (bus_addr_i == A_CTRL) && bus_wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) key_q <= '0;
    else if (key_wr) key_q[bus_addr_i[1:0]] <= bus_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0;
    end else if (load) begin
      for (int j = 0; j < NWORDS; j++) st_q[j] <= key_q[j] ^ fk_word(j);
    end else if (step) begin
      for (int j = 0; j < NWORDS - 1; j++) st_q[j] <= st_q[j+1];
      st_q[NWORDS-1] <= nxt;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (!bus_addr_i[2]) bus_rdata_o = key_q[bus_addr_i[1:0]];
    else if (bus_addr_i == A_CTRL) bus_rdata_o = {30'd0, done, busy};
  end

  ks_ctrl #(
    .ROUNDS(ROUNDS),
    .RND_W (RND_W)
  ) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_req),
    .busy_o (busy),
    .done_o (done),
    .load_o (load),
    .step_o (step),
    .rnd_o  (rnd)
  );

  ks_round #(
    .RND_W(RND_W)
  ) u_round (
    .st_i (st_q),
    .rnd_i(rnd),
    .nxt_o(nxt)
  );

  ks_rk_file #(
    .N (ROUNDS),
    .W (WORD_W),
    .AW(RND_W)
  ) u_rk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (step),
    .waddr_i(rnd),
    .wdata_i(nxt),
    .raddr_i(rd_idx_i),
    .rdec_i (rd_dec_i),
    .rdata_o(rd_key_o)
  );

  assert_key_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_we_i && !bus_addr_i[2]) |=> $stable(key_q));

  assert_busy_key_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !load) |=> ($past(st_q[1]) == st_q[0]));

endmodule

// File: tb/key_sched_engine_tb.sv
module key_sched_engine_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ROUNDS     = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [4:0]  rd_idx = '0;
  logic        rd_dec = 1'b0;
  logic [31:0] rd_key;

  key_sched_engine u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .bus_we_i   (bus_we),
    .bus_addr_i (bus_addr),
    .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata),
    .rd_idx_i   (rd_idx),
    .rd_dec_i   (rd_dec),
    .rd_key_o   (rd_key)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [31:0] val;
    int          idx;
    bit          dec;
    string       tag;
  } sb_item_t;

  sb_item_t    sb_q[$];
  sb_item_t    mon_it;
  int          n_chk = 0;
  int          n_fail = 0;
  int          cyc = 0;
  bit          finished = 1'b0;
  logic [7:0]  bm_sb[256];
  logic [31:0] exp_rk[ROUNDS];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pop one expected item per cycle and compare with the read port
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      mon_it = sb_q.pop_front();
      chk($sformatf("%s idx=%0d dec=%0d", mon_it.tag, mon_it.idx, mon_it.dec), rd_key, mon_it.val);
    end
  end

  function automatic logic [7:0] bm_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 8'h00;
    for (int k = 7; k >= 0; k--) begin
      r = {r[6:0], 1'b0} ^ (r[7] ? 8'h1B : 8'h00);
      if (b[k]) r = r ^ a;
    end
    return r;
  endfunction

  function automatic logic [7:0] bm_inv(input logic [7:0] x);
    if (x == 8'h00) return 8'h00;
    for (int y = 1; y < 256; y++) if (bm_mul(x, 8'(y)) == 8'h01) return 8'(y);
    return 8'h00;
  endfunction

  function automatic logic [7:0] bm_aff(input logic [7:0] y);
    logic [7:0] row = 8'hE5;
    logic [7:0] c = 8'hD3;
    logic [7:0] o;
    for (int k = 0; k < 8; k++) begin
      logic p = 1'b0;
      for (int m = 0; m < 8; m++) p = p ^ (y[m] & row[(m - k + 8) % 8]);
      o[k] = p ^ c[k];
    end
    return o;
  endfunction

  function automatic logic [31:0] bm_rotl(input logic [31:0] w, input int n);
    return (w << n) | (w >> (32 - n));
  endfunction

  task automatic model_expand(input logic [127:0] key);
    logic [31:0] x[4];
    logic [31:0] fk[4] = '{32'hA3B1BAC6, 32'h56AA3350, 32'h677D9197, 32'hB27022DC};
    for (int j = 0; j < 4; j++) x[j] = key[127-32*j -: 32] ^ fk[j];
    for (int i = 0; i < ROUNDS; i++) begin
      logic [31:0] ck, m, t, l;
      for (int j = 0; j < 4; j++) ck[31-8*j -: 8] = 8'(((4*i + j) * 7) % 256);
      m = x[1] ^ x[2] ^ x[3] ^ ck;
      for (int j = 0; j < 4; j++) t[8*j +: 8] = bm_sb[m[8*j +: 8]];
      l = t ^ bm_rotl(t, 13) ^ bm_rotl(t, 23);
      exp_rk[i] = x[0] ^ l;
      x[0] = x[1]; x[1] = x[2]; x[2] = x[3]; x[3] = exp_rk[i];
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic load_key(input logic [127:0] key);
    for (int j = 0; j < 4; j++) bus_wr(3'(j), key[127-32*j -: 32]);
  endtask

  task automatic wait_done(output int t1);
    logic [31:0] s;
    for (int g = 0; g < 1000; g++) begin
      bus_rd(3'd4, s);
      if (s[1]) break;
      @(negedge clk);
    end
    t1 = cyc;
  endtask

  // driver: push every forward and reverse read into the scoreboard
  task automatic sb_read_all(input string tag);
    for (int i = 0; i < ROUNDS; i++) begin
      for (int d = 0; d < 2; d++) begin
        sb_item_t it;
        #1;
        rd_idx = 5'(i);
        rd_dec = d[0];
        it.val = d[0] ? exp_rk[ROUNDS-1-i] : exp_rk[i];
        it.idx = i;
        it.dec = d[0];
        it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
      end
    end
    wait (sb_q.size() == 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0]  s;
    int           t0, t1;
    logic [127:0] key1 = 128'h01234567_89ABCDEF_FEDCBA98_76543210;
    logic [127:0] key2 = {128{1'b1}};
    logic [127:0] key3 = 128'hDEADBEEF_00000000_13579BDF_2468ACE0;

    for (int b = 0; b < 256; b++) bm_sb[b] = bm_aff(bm_inv(8'(b)));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    bus_rd(3'd4, s); chk("R1 status", s, 32'h0);
    for (int j = 0; j < 4; j++) begin bus_rd(3'(j), s); chk("R1 key word", s, 32'h0); end
    for (int i = 0; i < ROUNDS; i++) exp_rk[i] = '0;
    @(negedge clk);
    sb_read_all("R1 round key");

    // R2: key word map and readback
    load_key(key1);
    for (int j = 0; j < 4; j++) begin bus_rd(3'(j), s); chk("R2 key readback", s, key1[127-32*j -: 32]); end

    // R3: unmapped addresses, control write without start bit
    bus_rd(3'd5, s); chk("R3 addr5 reads zero", s, 32'h0);
    @(negedge clk);
    bus_wr(3'd6, 32'hFFFF_FFFF);
    bus_wr(3'd4, 32'hFFFF_FFFE);
    bus_rd(3'd0, s); chk("R3 key after unmapped write", s, key1[127:96]);
    bus_rd(3'd7, s); chk("R3 addr7 reads zero", s, 32'h0);
    bus_rd(3'd4, s); chk("R3 no start without bit0", s, 32'h0);
    @(negedge clk);

    // R7: timing of the first run
    bus_wr(3'd4, 32'h1);
    t0 = cyc;
    bus_rd(3'd4, s); chk("R3 busy flag", s, 32'h1);
    wait_done(t1);
    chk("R7 busy window", 32'(t1 - t0), 32'd32);
    bus_rd(3'd4, s); chk("R3 done flag", s, 32'h2);
    repeat (5) @(negedge clk);
    bus_rd(3'd4, s); chk("R8 done sticky", s, 32'h2);
    @(negedge clk);

    // R4 R5 R6 R11: full schedule, both directions
    model_expand(key1);
    sb_read_all("R4 R5 R6 R11 key1");

    // R8 R9 R10: start from done, then overwrite key and restart while busy
    load_key(key2);
    bus_wr(3'd4, 32'h1);
    t0 = cyc;
    bus_rd(3'd4, s); chk("R8 restart clears done", s, 32'h1);
    repeat (3) @(negedge clk);
    load_key(key3);
    bus_wr(3'd4, 32'h1);
    bus_rd(3'd4, s); chk("R9 still busy after ignored start", s, 32'h1);
    @(negedge clk);
    wait_done(t1);
    chk("R9 busy window kept", 32'(t1 - t0), 32'd32);
    for (int j = 0; j < 4; j++) begin bus_rd(3'(j), s); chk("R10 new key latched", s, key3[127-32*j -: 32]); end
    @(negedge clk);
    model_expand(key2);
    sb_read_all("R9 R10 key2 result");

    // R10: new key used by the next accepted start
    bus_wr(3'd4, 32'h1);
    wait_done(t1);
    @(negedge clk);
    model_expand(key3);
    sb_read_all("R10 R11 key3 result");

    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule